// File: doc/BRIEF.md
# HD Timing Reference and Line Number Inserter

This block sits in a 20-bit high-definition video word path. The upper ten bits carry luma and the lower ten bits carry chroma. Three timing inputs mark where each line starts and ends: horizontal blanking, vertical blanking and field. From these inputs the block writes the start and end timing reference sequences over the incoming words. Right after each end-of-line sequence it also writes two encoded line-number words. Every word that is not replaced passes through unchanged. The output follows the input after a fixed pipeline delay.

The horizontal input goes high on the first word of the end-of-active-video sequence. It stays high through the last word of the start-of-active-video sequence. The block therefore holds the stream four words back, so that it can see in advance where the horizontal input will fall. An internal line counter supplies the line number. It advances once per line and wraps at a configurable frame length. A falling edge on a separate strobe input forces the counter back to line 1. Separate enables control sequence insertion and line-number insertion. A select input marks that timing is being taken from the stream itself; while it is high, the line-number words are left alone.

Top module: `hd_trs_inserter`

## Requirements
- R1: With `trs_en_i` high, the first four words of each horizontal blanking interval (the word where `h_i` rises and the three after it) leave as 0x3FF, 0x000, 0x000, then a status word, written identically into both the luma half and the chroma half.
- R2: The status word has bit9 = 1, bit8 = F, bit7 = V, bit6 = H, bit5 = V^H, bit4 = F^H, bit3 = F^V, bit2 = F^V^H and bits 1:0 = 0. H is 1 in the end-of-line sequence and 0 in the start-of-line sequence. V and F are the `v_i` and `f_i` values that arrived with that status word.
- R3: With `trs_en_i` high, the last four words for which `h_i` is high, before it falls, are replaced by the start-of-line sequence in the same four-word form, on both channels.
- R4: With `trs_en_i` low, the words at the sequence positions leave unchanged.
- R5: With `ln_en_i` high and `stream_timing_i` low, the two words that follow the end-of-line status word become LN0 = {~L[6], L[6:0], 2'b00} and LN1 = {1'b1, 3'b000, L[10:7], 2'b00}, where L is the 11-bit line count. Both channels carry them.
- R6: With `ln_en_i` low, or with `stream_timing_i` high, those two word positions leave unchanged.
- R7: After reset the first line carries line number 1. Each later line carries the next number, and the count returns to 1 after `LINES_PER_FRAME`.
- R8: A high-to-low transition on `ln_reset_i` makes the next line number written equal to 1.
- R9: All other words leave unchanged. An input word sampled at one rising clock edge appears on `data_o` after the fifth rising edge that follows.
- R10: When `INTERLACED` is 0, the F bit of every status word is 0, whatever the value on `f_i`.
- R11: While `rst_ni` is low, and until new words reach the output, `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 20 | Input word, luma in 19:10, chroma in 9:0 |
| h_i | input | 1 | Horizontal blanking marker for the word on `data_i` |
| v_i | input | 1 | Vertical blanking marker |
| f_i | input | 1 | Field marker; held low for progressive formats |
| trs_en_i | input | 1 | Enables timing reference sequence insertion |
| ln_en_i | input | 1 | Enables line-number insertion |
| stream_timing_i | input | 1 | High when timing is taken from the stream; blocks line-number insertion |
| ln_reset_i | input | 1 | Line counter strobe; a falling edge sets the count to 1 |
| data_o | output | 20 | Output word after insertion |

## Verification
A position tracker that slips shows at the ports within the line where it slips. The four-word preamble appears shifted away from the rising edge of `h_i`. The start sequence no longer ends on the last word before `h_i` falls. Or the line-number words land on top of the preamble. A wrong line count shows as a wrong LN0/LN1 pair after the very next end-of-line sequence. A missed wrap or a missed strobe shows one line after it should have taken effect. The bench sweeps every combination of F, V and H, crosses the frame wrap twice, and checks every output word, so each of these faults is caught within one line.

// File: rtl/hd_trs_pkg.sv
`timescale 1ns/1ps
package hd_trs_pkg;
  localparam int WORD_W  = 10;
  localparam int TRS_LEN = 4;
  localparam int LINE_W  = 11;

  typedef enum logic [2:0] {
    SLOT_PASS,
    SLOT_EAV,
    SLOT_SAV,
    SLOT_LN0,
    SLOT_LN1
  } slot_e;

  function automatic logic [WORD_W-1:0] xyz_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] ln0_word(input logic [LINE_W-1:0] l);
    return {~l[6], l[6:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] ln1_word(input logic [LINE_W-1:0] l);
    return {1'b1, 3'b000, l[10:7], 2'b00};
  endfunction
endpackage

// File: rtl/hd_trs_delay_line.sv
`timescale 1ns/1ps
module hd_trs_delay_line #(
  parameter int DATA_W     = 20,
  parameter int DEPTH      = 5,
  parameter bit INTERLACED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              h_i,
  input  logic              v_i,
  input  logic              f_i,
  output logic [DATA_W-1:0] data_o,
  output logic              v_o,
  output logic              f_o,
  output logic [DEPTH-1:0]  h_pipe_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  h_q, v_q, f_q;
  logic              f_in;

  generate
    if (INTERLACED) begin : g_field
      assign f_in = f_i;
    end else begin : g_prog
      logic unused_f;
      assign unused_f = f_i;
      assign f_in     = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
      h_q <= '0;
      v_q <= '0;
      f_q <= '0;
    end else begin
      data_q[0] <= data_i;
      for (int i = 1; i < DEPTH; i++) data_q[i] <= data_q[i-1];
      h_q <= {h_q[DEPTH-2:0], h_i};
      v_q <= {v_q[DEPTH-2:0], v_i};
      f_q <= {f_q[DEPTH-2:0], f_in};
    end
  end

  assign data_o   = data_q[DEPTH-1];
  assign v_o      = v_q[DEPTH-1];
  assign f_o      = f_q[DEPTH-1];
  assign h_pipe_o = h_q;
endmodule

// File: rtl/hd_trs_locator.sv
`timescale 1ns/1ps
module hd_trs_locator
  import hd_trs_pkg::*;
#(
  parameter int DEPTH = TRS_LEN + 1,
  parameter int POS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] h_pipe_i,  // bit 0 newest, bit DEPTH-1 = word being processed
  output slot_e            slot_o,
  output logic [1:0]       idx_o,
  output logic             advance_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             h_cur, h_prev_q;
  logic [POS_W-1:0] pos_q, pos_c;
  logic             sav_hit;
  logic [1:0]       sav_idx;

  assign h_cur = h_pipe_i[DEPTH-1];

  always_comb begin
    if (h_cur && !h_prev_q)  pos_c = '0;
    else if (pos_q == POS_MAX) pos_c = pos_q;
    else                     pos_c = pos_q + 1'b1;
  end

  // nearest low H ahead of the current word selects the SAV word index
  always_comb begin
    sav_hit = 1'b0;
    sav_idx = '0;
    for (int j = TRS_LEN; j >= 1; j--) begin
      if (!h_pipe_i[DEPTH-1-j]) begin
        sav_hit = 1'b1;
        sav_idx = 2'(TRS_LEN - j);
      end
    end
  end

  always_comb begin
    slot_o = SLOT_PASS;
    idx_o  = '0;
    if (h_cur) begin
      if (pos_c < POS_W'(TRS_LEN)) begin
        slot_o = SLOT_EAV;
        idx_o  = pos_c[1:0];
      end else if (pos_c == POS_W'(TRS_LEN)) begin
        slot_o = SLOT_LN0;
      end else if (pos_c == POS_W'(TRS_LEN + 1)) begin
        slot_o = SLOT_LN1;
      end else if (sav_hit) begin
        slot_o = SLOT_SAV;
        idx_o  = sav_idx;
      end
    end
  end

  assign advance_o = (slot_o == SLOT_LN1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_prev_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      h_prev_q <= h_cur;
      pos_q    <= pos_c;
    end
  end
endmodule

// File: rtl/hd_line_counter.sv
`timescale 1ns/1ps
module hd_line_counter #(
  parameter int LINES  = 1125,
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              advance_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] ONE  = LINE_W'(1);

  logic strobe_q;
  logic fall;

  assign fall = strobe_q & ~strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      line_o   <= ONE;
    end else begin
      strobe_q <= strobe_i;
      if (fall)                line_o <= ONE;
      else if (advance_i)      line_o <= (line_o == LAST) ? ONE : line_o + 1'b1;
    end
  end
endmodule

// File: rtl/hd_trs_inserter.sv
`timescale 1ns/1ps
module hd_trs_inserter
  import hd_trs_pkg::*;
#(
  parameter int LINES_PER_FRAME = 1125,
  parameter bit INTERLACED      = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [19:0] data_i,
  input  logic        h_i,
  input  logic        v_i,
  input  logic        f_i,
  input  logic        trs_en_i,
  input  logic        ln_en_i,
  input  logic        stream_timing_i,
  input  logic        ln_reset_i,
  output logic [19:0] data_o
);
  localparam int DATA_W = 2 * WORD_W;
  localparam int DEPTH  = TRS_LEN + 1;

  logic [DATA_W-1:0] data_cur;
  logic              v_cur, f_cur, h_cur;
  logic [DEPTH-1:0]  h_pipe;
  slot_e             slot;
  logic [1:0]        slot_idx;
  logic              advance;
  logic [LINE_W-1:0] line_cnt;
  logic [WORD_W-1:0] trs_w;
  logic [DATA_W-1:0] data_nx;

  hd_trs_delay_line #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .INTERLACED(INTERLACED)
  ) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .h_i(h_i), .v_i(v_i), .f_i(f_i),
    .data_o(data_cur), .v_o(v_cur), .f_o(f_cur), .h_pipe_o(h_pipe)
  );

  assign h_cur = h_pipe[DEPTH-1];

  hd_trs_locator #(.DEPTH(DEPTH)) u_loc (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_pipe_i(h_pipe),
    .slot_o(slot), .idx_o(slot_idx), .advance_o(advance)
  );

  hd_line_counter #(.LINES(LINES_PER_FRAME), .LINE_W(LINE_W)) u_lcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(ln_reset_i),
    .advance_i(advance), .line_o(line_cnt)
  );

  always_comb begin
    case (slot_idx)
      2'd0:    trs_w = '1;
      2'd3:    trs_w = xyz_word(f_cur, v_cur, slot == SLOT_EAV);
      default: trs_w = '0;
    endcase
  end

  always_comb begin
    data_nx = data_cur;
    case (slot)
      SLOT_EAV, SLOT_SAV: if (trs_en_i) data_nx = {trs_w, trs_w};
      SLOT_LN0: if (ln_en_i && !stream_timing_i) data_nx = {2{ln0_word(line_cnt)}};
      SLOT_LN1: if (ln_en_i && !stream_timing_i) data_nx = {2{ln1_word(line_cnt)}};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= data_nx;
  end
endmodule

// File: rtl/hd_trs_inserter_chk.sv
`timescale 1ns/1ps
module hd_trs_inserter_chk
  import hd_trs_pkg::*;
#(
  parameter int LINES = 1125
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trs_en_i,
  input logic              stream_timing_i,
  input logic              ln_reset_i,
  input logic [19:0]       data_o,
  input logic [19:0]       data_cur,
  input logic              h_cur,
  input slot_e             slot,
  input logic [1:0]        slot_idx,
  input logic [LINE_W-1:0] line_cnt
);
  p_eav_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SLOT_EAV && slot_idx == 2'd0) |=> (slot == SLOT_EAV && slot_idx == 2'd1));

  p_preamble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trs_en_i && slot == SLOT_EAV && slot_idx == 2'd0) |=> (data_o == 20'hFFFFF));

  p_xyz_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trs_en_i && (slot == SLOT_EAV || slot == SLOT_SAV) && slot_idx == 2'd3) |=>
      (data_o[19:10] == data_o[9:0] && data_o[19] && data_o[11:10] == 2'b00 &&
       data_o[15] == (data_o[17] ^ data_o[16]) &&
       data_o[14] == (data_o[18] ^ data_o[16]) &&
       data_o[13] == (data_o[18] ^ data_o[17]) &&
       data_o[12] == (data_o[18] ^ data_o[17] ^ data_o[16])));

  p_sav_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SLOT_SAV && slot_idx == 2'd3) |=> !h_cur);

  p_ln_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stream_timing_i && (slot == SLOT_LN0 || slot == SLOT_LN1)) |=> (data_o == $past(data_cur)));

  p_line_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt >= LINE_W'(1) && line_cnt <= LINE_W'(LINES)));

  p_ln_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ln_reset_i) && !ln_reset_i) |=> (line_cnt == LINE_W'(1)));
endmodule

bind hd_trs_inserter hd_trs_inserter_chk #(.LINES(LINES_PER_FRAME)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trs_en_i(trs_en_i),
  .stream_timing_i(stream_timing_i), .ln_reset_i(ln_reset_i),
  .data_o(data_o), .data_cur(data_cur), .h_cur(h_cur),
  .slot(slot), .slot_idx(slot_idx), .line_cnt(line_cnt)
);

// File: tb/hd_trs_inserter_bench.sv
`timescale 1ns/1ps
module hd_trs_inserter_bench;
  localparam int LINES    = 6;
  localparam int LINE_LEN = 40;
  localparam int HBLK     = 16;
  localparam int LAG      = 6;
  localparam int NMAX     = 2048;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [19:0] data_in;
  logic        h, v, f, trs_en, ln_en, stm, ln_rst;
  logic [19:0] data_out, data_out_p;

  hd_trs_inserter #(.LINES_PER_FRAME(LINES), .INTERLACED(1'b1)) u_hd_trs_inserter (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_in), .h_i(h), .v_i(v), .f_i(f),
    .trs_en_i(trs_en), .ln_en_i(ln_en), .stream_timing_i(stm),
    .ln_reset_i(ln_rst), .data_o(data_out)
  );

  hd_trs_inserter #(.LINES_PER_FRAME(LINES), .INTERLACED(1'b0)) u_hd_trs_inserter_prog (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_in), .h_i(h), .v_i(v), .f_i(f),
    .trs_en_i(trs_en), .ln_en_i(ln_en), .stream_timing_i(stm),
    .ln_reset_i(ln_rst), .data_o(data_out_p)
  );

  logic [19:0] exp_m [NMAX];
  logic [19:0] exp_p [NMAX];
  string       req_s [NMAX];
  int cyc = 0, n_chk = 0, n_bad = 0, lc = 1;
  bit done = 1'b0;

  function automatic logic [9:0] bxyz(int ff, int vv, int hh);
    return 10'(512 + ff*256 + vv*128 + hh*64 + (vv^hh)*32 + (ff^hh)*16 + (ff^vv)*8 + (ff^vv^hh)*4);
  endfunction

  function automatic logic [9:0] bln0(int l);
    return 10'(((l % 128) * 4) + ((((l / 64) % 2) ^ 1) * 512));
  endfunction

  function automatic logic [9:0] bln1(int l);
    return 10'(512 + ((l / 128) % 16) * 4);
  endfunction

  function automatic logic [19:0] pat(int c);
    return {10'((c*37 + 11) % 1024), 10'((c*53 + 7) % 1024)};
  endfunction

  task automatic chk(logic [19:0] act, logic [19:0] expv, string rq);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, expv);
    end
  endtask

  task automatic step(logic [19:0] d, logic hh, logic vv, logic ff,
                      logic [19:0] em, logic [19:0] ep, string rq);
    @(negedge clk);
    if (cyc >= LAG) begin
      chk(data_out,   exp_m[cyc-LAG], req_s[cyc-LAG]);
      chk(data_out_p, exp_p[cyc-LAG], {"R10/", req_s[cyc-LAG]});
    end
    data_in = d; h = hh; v = vv; f = ff;
    exp_m[cyc] = em; exp_p[cyc] = ep; req_s[cyc] = rq;
    cyc++;
  endtask

  // one line: EAV at 0..3, LN at 4..5, SAV at HBLK-4..HBLK-1, active after
  task automatic send_line(string ln_tag, bit strobe);
    int L, vi, fi;
    L  = lc;
    vi = (L <= 2) ? 1 : 0;
    fi = L % 2;
    lc = (lc == LINES) ? 1 : lc + 1;
    for (int w = 0; w < LINE_LEN; w++) begin
      logic [19:0] d, em, ep;
      logic [9:0]  wm, wp;
      string rq;
      d = pat(cyc); em = d; ep = d; rq = "R9";
      if (w < 4 || (w >= HBLK-4 && w < HBLK)) begin
        int k, hb;
        k  = (w < 4) ? w : w - (HBLK-4);
        hb = (w < 4) ? 1 : 0;
        if (trs_en) begin
          wm = (k == 0) ? 10'h3FF : (k == 3) ? bxyz(fi, vi, hb) : 10'h000;
          wp = (k == 3) ? bxyz(0, vi, hb) : wm;
          em = {wm, wm}; ep = {wp, wp};
          rq = (k == 3) ? "R2" : (w < 4) ? "R1" : "R3";
        end else rq = "R4";
      end else if (w == 4 || w == 5) begin
        if (ln_en && !stm) begin
          wm = (w == 4) ? bln0(L) : bln1(L);
          em = {wm, wm}; ep = em; rq = ln_tag;
        end else rq = "R6";
      end
      if (strobe && w == 25) begin ln_rst = 1'b0; lc = 1; end
      if (strobe && w == 30) ln_rst = 1'b1;
      step(d, w < HBLK, vi[0], fi[0], em, ep, rq);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; data_in = '0; h = 0; v = 0; f = 0;
    trs_en = 1; ln_en = 1; stm = 0; ln_rst = 1;
    repeat (4) @(negedge clk);
    chk(data_out, 20'h0, "R11");
    chk(data_out_p, 20'h0, "R11");
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_out, 20'h0, "R11");
    // two frames plus two lines: line numbers wrap twice
    for (int i = 0; i < 14; i++) send_line("R7", 1'b0);
    stm = 1;
    for (int i = 0; i < 3; i++) send_line("R5", 1'b0);
    stm = 0; trs_en = 0;
    for (int i = 0; i < 3; i++) send_line("R5", 1'b0);
    trs_en = 1; ln_en = 0;
    for (int i = 0; i < 2; i++) send_line("R5", 1'b0);
    ln_en = 1;
    send_line("R5", 1'b1);
    for (int i = 0; i < 3; i++) send_line("R8", 1'b0);
    for (int i = 0; i < LAG + 2; i++) step(pat(cyc), 1'b0, 1'b0, 1'b0, pat(cyc), pat(cyc), "R9");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule